// File: doc/BRIEF.md
# Bit-Serial Integer Multiply/Divide Unit

This block is the multiply and divide engine of a small in-order 32-bit integer core. The core hands it two operands and a three-bit operation code with a one-cycle start pulse. The unit then works through the operation one bit per clock and returns a 32-bit result with a one-cycle done pulse. It covers the full set of eight integer multiply, high-multiply, divide and remainder operations, in signed, unsigned and mixed-sign forms.

A single datapath serves all eight operations. The operands are first reduced to unsigned magnitudes. A shared pair of shift registers then runs either a shift-add multiply or a restoring divide for exactly 32 steps. One last stage restores the sign and selects the low or high product half, or the quotient or the remainder. Division by zero and signed overflow produce the fixed results that the integer ISA defines, and they raise no trap.

Top module: `serial_muldiv`

## Requirements
- R1: Op code 0 returns the low 32 bits of the product. The result does not depend on how the operands are signed.
- R2: Op code 1 returns the upper 32 bits of the 64-bit product, with both operands taken as two's-complement signed.
- R3: Op code 2 returns the upper 32 bits of the 64-bit product, with the first operand taken as signed and the second as unsigned.
- R4: Op code 3 returns the upper 32 bits of the 64-bit product, with both operands taken as unsigned.
- R5: Op codes 4 (signed) and 5 (unsigned) return the quotient, truncated toward zero. Op codes 6 (signed) and 7 (unsigned) return the remainder, and a signed remainder carries the sign of the dividend.
- R6: When the divisor is zero, op codes 4 and 5 return all ones, and op codes 6 and 7 return the dividend unchanged.
- R7: The signed division 0x80000000 / 0xFFFFFFFF returns 0x80000000 for op code 4 and returns 0 for op code 6.
- R8: The operation code is 3 bits wide. The values are 0 for the low product, 1 for the signed high product, 2 for the signed-by-unsigned high product, 3 for the unsigned high product, 4 for the signed quotient, 5 for the unsigned quotient, 6 for the signed remainder and 7 for the unsigned remainder.
- R9: A start pulse seen while busy is low is accepted. Busy is high from the next cycle onward. Done is high for exactly one cycle, 33 rising edges after the accepting edge, and busy is low in that cycle.
- R10: A start pulse that arrives while busy is high is ignored. The running operation completes on time with its own result.
- R11: The result output stays unchanged from one done pulse until the next.
- R12: While reset is high and right after it, busy and done are low and the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_i | input | 3 | Operation code (see R8) |
| opa_i | input | 32 | First operand: multiplicand or dividend |
| opb_i | input | 32 | Second operand: multiplier or divisor |
| busy_o | output | 1 | High while an accepted operation is in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| result_o | output | 32 | Result, held until the next completion |

## Verification
Each operation code is tried with small positive operands, which check the plain arithmetic. Each is also tried with operands whose top bit is set, and these tell signed, unsigned and mixed-sign handling apart. For example, the same bit patterns give different high products under op codes 1, 2 and 3. Division is run with every sign combination of dividend and divisor, to separate truncation toward zero from floor behaviour and to check the sign of the remainder. A zero divisor and the most-negative-by-minus-one case each get their own vectors. Directed runs measure the latency and the busy window, send a start while busy, and watch the result for stability between completions.

// File: rtl/smd_pkg.sv
package smd_pkg;

    // Operation code; the numbering follows the integer ISA's function field.
    typedef enum logic [2:0] {
        OP_MUL    = 3'd0,
        OP_MULH   = 3'd1,
        OP_MULHSU = 3'd2,
        OP_MULHU  = 3'd3,
        OP_DIV    = 3'd4,
        OP_DIVU   = 3'd5,
        OP_REM    = 3'd6,
        OP_REMU   = 3'd7
    } smd_op_e;

    // Control word decoded from the op code.
    typedef struct packed {
        logic is_div;    // divide family
        logic pick_alt;  // high product half, or remainder
        logic sgn_a;     // first operand is signed
        logic sgn_b;     // second operand is signed
    } smd_dec_t;

    // Fix-up word kept for the whole run.
    typedef struct packed {
        logic is_div;
        logic pick_alt;
        logic neg_main;  // negate product, or quotient
        logic neg_rem;   // negate remainder
    } smd_fix_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } smd_state_e;

    function automatic smd_dec_t smd_decode(smd_op_e op);
        smd_dec_t d;
        d.is_div   = op[2];
        d.pick_alt = op[2] ? op[1] : (op != OP_MUL);
        d.sgn_a    = (op == OP_MULH) || (op == OP_MULHSU) ||
                     (op == OP_DIV)  || (op == OP_REM);
        d.sgn_b    = (op == OP_MULH) || (op == OP_DIV) || (op == OP_REM);
        return d;
    endfunction

endpackage

// File: rtl/smd_prep.sv
module smd_prep
    import smd_pkg::*;
#(
    parameter int W = 32
) (
    input  smd_op_e         op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output smd_fix_t        fix,
    output logic [W-1:0]    mag_a,
    output logic [W-1:0]    mag_b
);
    smd_dec_t dec;
    logic     neg_a, neg_b, b_zero;

    always_comb begin
        dec    = smd_decode(op);
        neg_a  = dec.sgn_a & a[W-1];
        neg_b  = dec.sgn_b & b[W-1];
        b_zero = (b == '0);
        mag_a  = neg_a ? (~a + 1'b1) : a;
        mag_b  = neg_b ? (~b + 1'b1) : b;
        fix.is_div   = dec.is_div;
        fix.pick_alt = dec.pick_alt;
        // A zero divisor keeps the all-ones quotient unsigned.
        fix.neg_main = (neg_a ^ neg_b) & ~(dec.is_div & b_zero);
        fix.neg_rem  = neg_a;
    end
endmodule

// File: rtl/smd_core.sv
module smd_core
    import smd_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         is_div_i,
    input  logic [W-1:0] mag_a_i,
    input  logic [W-1:0] mag_b_i,
    output logic         busy_o,
    output logic         fin_o,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    localparam int CW = $clog2(W);

    smd_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          div_q;
    logic [W-1:0]  hi_q, lo_q, m_q;

    logic [W:0]    mul_sum;
    logic [W:0]    div_sh;
    logic [W+1:0]  div_diff;
    logic          ge;

    always_comb begin
        mul_sum  = {1'b0, hi_q} + (lo_q[0] ? {1'b0, m_q} : {(W+1){1'b0}});
        div_sh   = {hi_q, lo_q[W-1]};
        div_diff = {1'b0, div_sh} - {2'b00, m_q};
        ge       = ~div_diff[W+1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            div_q   <= 1'b0;
            hi_q    <= '0;
            lo_q    <= '0;
            m_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (load_i) begin
                    state_q <= ST_RUN;
                    cnt_q   <= '0;
                    div_q   <= is_div_i;
                    hi_q    <= '0;
                    lo_q    <= is_div_i ? mag_a_i : mag_b_i;
                    m_q     <= is_div_i ? mag_b_i : mag_a_i;
                end
                ST_RUN: begin
                    if (div_q) begin
                        hi_q <= ge ? div_diff[W-1:0] : div_sh[W-1:0];
                        lo_q <= {lo_q[W-2:0], ge};
                    end else begin
                        hi_q <= mul_sum[W:1];
                        lo_q <= {mul_sum[0], lo_q[W-1:1]};
                    end
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CW'(W-1)) state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE);
    assign fin_o  = (state_q == ST_DONE);
    assign hi_o   = hi_q;
    assign lo_o   = lo_q;
endmodule

// File: rtl/smd_fix.sv
module smd_fix
    import smd_pkg::*;
#(
    parameter int W = 32
) (
    input  smd_fix_t     fix,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] lo,
    output logic [W-1:0] res
);
    logic [2*W-1:0] prod;
    logic [W-1:0]   quot, rem;

    always_comb begin
        prod = fix.neg_main ? (~{hi, lo} + 1'b1) : {hi, lo};
        quot = fix.neg_main ? (~lo + 1'b1) : lo;
        rem  = fix.neg_rem  ? (~hi + 1'b1) : hi;
        if (fix.is_div) res = fix.pick_alt ? rem : quot;
        else            res = fix.pick_alt ? prod[2*W-1:W] : prod[W-1:0];
    end
endmodule

// File: rtl/serial_muldiv.sv
module serial_muldiv
    import smd_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [2:0]   op_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] result_o
);
    smd_fix_t     fix_in, fix_q;
    logic [W-1:0] mag_a, mag_b, hi, lo, fixed;
    logic         core_busy, fin, go;
    logic         done_q;
    logic [W-1:0] result_q;

    assign go = start_i & ~core_busy;

    smd_prep #(.W(W)) u_prep (
        .op(smd_op_e'(op_i)), .a(opa_i), .b(opb_i),
        .fix(fix_in), .mag_a(mag_a), .mag_b(mag_b)
    );

    smd_core #(.W(W)) u_core (
        .clk(clk), .rst(rst), .load_i(go), .is_div_i(fix_in.is_div),
        .mag_a_i(mag_a), .mag_b_i(mag_b),
        .busy_o(core_busy), .fin_o(fin), .hi_o(hi), .lo_o(lo)
    );

    smd_fix #(.W(W)) u_fix (
        .fix(fix_q), .hi(hi), .lo(lo), .res(fixed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fix_q    <= '0;
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            if (go) fix_q <= fix_in;
            done_q <= fin;
            if (fin) result_q <= fixed;
        end
    end

    assign busy_o   = core_busy;
    assign done_o   = done_q;
    assign result_o = result_q;
endmodule

// File: rtl/smd_checker.sv
module smd_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] result_o
);
    localparam int LAT = W + 1;
    localparam int CW  = $clog2(LAT + 1) + 1;

    logic          run_q;
    logic [CW-1:0] cnt_q;
    logic          accept;

    assign accept = start_i & ~busy_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (accept) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (done_o) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R9
    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o); // R9
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy_o); // R9
    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (run_q && cnt_q == CW'(LAT))); // R9
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (run_q && start_i && !done_o) |=> (run_q && cnt_q == $past(cnt_q) + 1'b1)); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(result_o)); // R11
endmodule

bind serial_muldiv smd_checker #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .result_o(result_o)
);

// File: tb/serial_muldiv_bench.sv
`timescale 1ns/1ps
module serial_muldiv_bench;
    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 32'd6,          32'd7,          32'd42,         8'd1}, // R1
        '{3'd0, 32'hFFFFFFFF,   32'd3,          32'hFFFFFFFD,   8'd1}, // R1
        '{3'd0, 32'h12345678,   32'h10,         32'h23456780,   8'd1}, // R1
        '{3'd1, 32'hFFFFFFFF,   32'd3,          32'hFFFFFFFF,   8'd2}, // R2
        '{3'd1, 32'h80000000,   32'h80000000,   32'h40000000,   8'd2}, // R2
        '{3'd2, 32'hFFFFFFFF,   32'hFFFFFFFF,   32'hFFFFFFFF,   8'd3}, // R3
        '{3'd2, 32'd2,          32'h80000000,   32'd1,          8'd3}, // R3
        '{3'd2, 32'h80000000,   32'd2,          32'hFFFFFFFF,   8'd3}, // R3
        '{3'd3, 32'hFFFFFFFF,   32'hFFFFFFFF,   32'hFFFFFFFE,   8'd4}, // R4
        '{3'd3, 32'h80000000,   32'd2,          32'd1,          8'd4}, // R4
        '{3'd4, 32'hFFFFFFF9,   32'd2,          32'hFFFFFFFD,   8'd5}, // R5
        '{3'd6, 32'hFFFFFFF9,   32'd2,          32'hFFFFFFFF,   8'd5}, // R5
        '{3'd4, 32'd7,          32'hFFFFFFFE,   32'hFFFFFFFD,   8'd5}, // R5
        '{3'd6, 32'd7,          32'hFFFFFFFE,   32'd1,          8'd5}, // R5
        '{3'd5, 32'hFFFFFFF9,   32'd2,          32'h7FFFFFFC,   8'd5}, // R5
        '{3'd7, 32'hFFFFFFF9,   32'd2,          32'd1,          8'd5}, // R5
        '{3'd4, 32'd100,        32'd10,         32'd10,         8'd5}, // R5
        '{3'd6, 32'd100,        32'd7,          32'd2,          8'd5}, // R5
        '{3'd4, 32'hFFFFFFF9,   32'd0,          32'hFFFFFFFF,   8'd6}, // R6
        '{3'd5, 32'd5,          32'd0,          32'hFFFFFFFF,   8'd6}, // R6
        '{3'd6, 32'hFFFFFFF9,   32'd0,          32'hFFFFFFF9,   8'd6}, // R6
        '{3'd7, 32'd5,          32'd0,          32'd5,          8'd6}, // R6
        '{3'd4, 32'h80000000,   32'hFFFFFFFF,   32'h80000000,   8'd7}, // R7
        '{3'd6, 32'h80000000,   32'hFFFFFFFF,   32'd0,          8'd7}, // R7
        '{3'd5, 32'h80000000,   32'hFFFFFFFF,   32'd0,          8'd8}, // R8
        '{3'd7, 32'h80000000,   32'hFFFFFFFF,   32'h80000000,   8'd8}  // R8
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        busy_o, done_o;
    logic [31:0] result_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    serial_muldiv u_serial_muldiv (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o),
        .done_o(done_o), .result_o(result_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive a start before an edge; return the result and the edge count to done.
    task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                          output logic [31:0] res, output int lat);
        @(negedge clk);
        start_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        res = result_o;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R9 watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] res, held;
        int lat;

        repeat (3) @(negedge clk);
        // R12: state during reset
        check("R12 busy", {31'd0, busy_o}, 32'd0);
        check("R12 done", {31'd0, done_o}, 32'd0);
        check("R12 result", result_o, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R12 busy after", {31'd0, busy_o}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i].op, VEC[i].a, VEC[i].b, res, lat);
            check($sformatf("R%0d vec%0d", VEC[i].req, i), res, VEC[i].exp);
        end

        // R9: busy window and latency
        @(negedge clk);
        start_i = 1'b1; op_i = 3'd5; opa_i = 32'd1000; opb_i = 32'd3;
        @(negedge clk);
        start_i = 1'b0;
        check("R9 busy after accept", {31'd0, busy_o}, 32'd1);
        lat = 0;
        while (!done_o && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        check("R9 latency", lat, 32'd33);
        check("R9 busy at done", {31'd0, busy_o}, 32'd0);
        check("R9 result", result_o, 32'd333);
        @(negedge clk);
        check("R9 done one cycle", {31'd0, done_o}, 32'd0);

        // R11: result held between completions
        held = result_o;
        repeat (10) @(negedge clk);
        check("R11 result held", result_o, held);

        // R10: start while busy is ignored
        @(negedge clk);
        start_i = 1'b1; op_i = 3'd7; opa_i = 32'd100; opb_i = 32'd7;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        start_i = 1'b1; op_i = 3'd0; opa_i = 32'd6; opb_i = 32'd7;
        @(negedge clk);
        start_i = 1'b0;
        lat = 6;
        while (!done_o && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        check("R10 result of first op", result_o, 32'd2);
        check("R10 latency unchanged", lat, 32'd33);
        @(negedge clk);
        check("R10 no second done", {31'd0, done_o}, 32'd0);
        check("R10 idle after", {31'd0, busy_o}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule